// File: doc/BRIEF.md
# Fuzzy Rule Weight Decoder

This block works out how strongly each of four fuzzy rules fires for a two-input controller. Both inputs arrive already fuzzified, each as a trapezoid of four points on a 64-position universe. Every rule has one trapezoidal antecedent for input X and one for input Y. One start strobe launches a pass. In each pass the four rules go one after another through a single pair of matching-degree units: one unit compares X with the X antecedent and the other compares Y with the Y antecedent, both in the same cycle. The smaller of the two degrees is the rule weight. A selector chooses which rule's antecedents reach the units, and a distributor writes the resulting weight into that rule's own register.

Each rule occupies the shared units for two clock cycles, so a pass takes eight cycles. A done pulse follows the pass. For a 16-rule controller, four copies run side by side. Copy i handles rules 4i to 4i+3, so every copy processes its first local rule in the first two cycles, its second in the next two, and so on. Consequent evaluation and defuzzification are handled elsewhere.

A trapezoid is packed as four 6-bit points, p1 at bits [5:0], p2 at [11:6], p3 at [17:12] and p4 at [23:18], with p1 <= p2 <= p3 <= p4. Rule r takes bits [r*24 +: 24] of an antecedent bus. Weight r takes bits [r*4 +: 4] of the weight bus. Grades are 4 bits wide, where 0 means no membership and 15 means full membership.

Top module: `rule_weight_decoder`

## Requirements
- R1: While reset is held, and after it is released until the first completed pass, every weight reads 0 and done is low.
- R2: For an input trapezoid x and an antecedent a, the matching degree is 0 when a.p4 <= x.p1 or x.p4 <= a.p1, and this test takes priority over all others.
- R3: When neither R2 nor the crossing conditions of R4 and R5 hold, the plateaus overlap and the degree is 15. This includes an input identical to its antecedent.
- R4: When the input lies to the right (a.p3 < x.p2), the degree is floor(15*q/(p+q)) with p = x.p2 - a.p3 and q = a.p4 - x.p1.
- R5: When the input lies to the left (x.p3 < a.p2), the degree is floor(15*q/(p+q)) with p = a.p2 - x.p3 and q = x.p4 - a.p1.
- R6: Each rule weight is the minimum of its X degree and its Y degree.
- R7: If start is sampled high at an edge while idle, done is high for exactly one cycle, after the eighth following edge. All four new weights are visible in that same cycle.
- R8: Weights are written in rule order 0, 1, 2, 3. Weight k takes its new value at the edge 2k+2 after the accepting edge, and the slots not yet written keep their old values until then.
- R9: A start that arrives during a pass is ignored. It neither moves the done pulse nor triggers a second pass.
- R10: Between passes the weights hold their values, even if the inputs or antecedents change. Inputs and antecedents must stay stable throughout a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a pass when idle |
| xIn | input | 24 | Fuzzified input X, packed trapezoid |
| yIn | input | 24 | Fuzzified input Y, packed trapezoid |
| antX | input | 96 | X antecedents of the four rules |
| antY | input | 96 | Y antecedents of the four rules |
| weights | output | 16 | Four 4-bit rule weights |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
If the step counter has an error, weights are written into the wrong slots or at the wrong time. That shows at the weight port within two cycles of the affected rule, and it also moves the done pulse away from the ninth cycle after start. An error in the classification of the matching unit gives a wrong weight value for that rule by the end of the same pass. An error in the busy state either lets a second start restart the pass, which delays done, or makes done appear again without a start.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  localparam int RULE_COUNT = 4;
  localparam int SEL_W = $clog2(RULE_COUNT);

  typedef struct packed {
    logic             loadStage;
    logic             writeWeight;
    logic [SEL_W-1:0] ruleSel;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    MATCH_NONE  = 2'd0,
    MATCH_FULL  = 2'd1,
    MATCH_CROSS = 2'd2
  } matchKind_e;
endpackage

// File: rtl/rwd_match_unit.sv
module rwd_match_unit
  import rwd_pkg::*;
#(
  parameter int PTW = 6,
  parameter int GW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [4*PTW-1:0] ant,
  input  logic [4*PTW-1:0] inp,
  output logic [GW-1:0]    degree
);
  localparam int PW = PTW + GW;
  localparam logic [GW-1:0] GMAX = '1;

  logic [PTW-1:0] a1, a2, a3, a4, x1, x2, x3, x4;
  assign {a4, a3, a2, a1} = ant;
  assign {x4, x3, x2, x1} = inp;

  matchKind_e   kindNext, kindQ;
  logic [PTW-1:0] nearNext, nearQ;
  logic [PTW:0]   spanNext, spanQ;

  // first half: classify the overlap and form the crossing terms
  always_comb begin
    kindNext = MATCH_FULL;
    nearNext = '0;
    spanNext = '0;
    if (a4 <= x1 || x4 <= a1) begin
      kindNext = MATCH_NONE;
    end else if (a3 < x2) begin
      kindNext = MATCH_CROSS;
      nearNext = a4 - x1;
      spanNext = {1'b0, x2 - a3} + {1'b0, a4 - x1};
    end else if (x3 < a2) begin
      kindNext = MATCH_CROSS;
      nearNext = x4 - a1;
      spanNext = {1'b0, a2 - x3} + {1'b0, x4 - a1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= MATCH_NONE;
      nearQ <= '0;
      spanQ <= '0;
    end else if (load) begin
      kindQ <= kindNext;
      nearQ <= nearNext;
      spanQ <= spanNext;
    end
  end

  // second half: scale and divide to obtain the crossing grade
  logic [PW-1:0] scaled, spanExt;
  assign scaled  = PW'(nearQ) * PW'(GMAX);
  assign spanExt = PW'(spanQ);

  always_comb begin
    unique case (kindQ)
      MATCH_FULL:  degree = GMAX;
      MATCH_CROSS: degree = (spanQ == '0) ? '0 : GW'(scaled / spanExt);
      default:     degree = '0;
    endcase
  end
endmodule

// File: rtl/rwd_datapath.sv
module rwd_datapath
  import rwd_pkg::*;
#(
  parameter int PTW = 6,
  parameter int GW  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strobe,
  input  logic [4*PTW-1:0]            xIn,
  input  logic [4*PTW-1:0]            yIn,
  input  logic [RULE_COUNT*4*PTW-1:0] antX,
  input  logic [RULE_COUNT*4*PTW-1:0] antY,
  output logic [RULE_COUNT*GW-1:0]    weights
);
  localparam int TW = 4 * PTW;
  localparam int AXES = 2;

  logic [TW-1:0] selAnt [AXES];
  logic [TW-1:0] axisIn [AXES];
  logic [GW-1:0] deg    [AXES];
  logic [GW-1:0] wNew;

  assign selAnt[0] = antX[strobe.ruleSel*TW +: TW];
  assign selAnt[1] = antY[strobe.ruleSel*TW +: TW];
  assign axisIn[0] = xIn;
  assign axisIn[1] = yIn;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    rwd_match_unit #(.PTW(PTW), .GW(GW)) match_i (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.loadStage),
      .ant    (selAnt[g]),
      .inp    (axisIn[g]),
      .degree (deg[g])
    );
  end

  assign wNew = (deg[0] < deg[1]) ? deg[0] : deg[1];

  for (genvar k = 0; k < RULE_COUNT; k++) begin : g_slot
    logic [GW-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.writeWeight && strobe.ruleSel == SEL_W'(k)) begin
        slotQ <= wNew;
      end
    end
    assign weights[k*GW +: GW] = slotQ;
  end
endmodule

// File: rtl/rwd_ctrl.sv
module rwd_ctrl
  import rwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int STEPS = 2 * RULE_COUNT;
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] stepQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      stepQ <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          stepQ <= '0;
        end
      end else if (stepQ == LAST) begin
        busy  <= 1'b0;
        stepQ <= '0;
        done  <= 1'b1;
      end else begin
        stepQ <= stepQ + 1'b1;
      end
    end
  end

  assign strobe.loadStage   = busy & ~stepQ[0];
  assign strobe.writeWeight = busy & stepQ[0];
  assign strobe.ruleSel     = stepQ[CW-1:1];
endmodule

// File: rtl/rule_weight_decoder.sv
module rule_weight_decoder
  import rwd_pkg::*;
#(
  parameter int PTW = 6,
  parameter int GW  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [4*PTW-1:0]            xIn,
  input  logic [4*PTW-1:0]            yIn,
  input  logic [RULE_COUNT*4*PTW-1:0] antX,
  input  logic [RULE_COUNT*4*PTW-1:0] antY,
  output logic [RULE_COUNT*GW-1:0]    weights,
  output logic                        done
);
  seqStrobe_t seqStrobe;
  logic       busy;

  rwd_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (seqStrobe),
    .busy   (busy),
    .done   (done)
  );

  rwd_datapath #(.PTW(PTW), .GW(GW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (seqStrobe),
    .xIn     (xIn),
    .yIn     (yIn),
    .antX    (antX),
    .antY    (antY),
    .weights (weights)
  );
endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          loadStage,
  input logic          writeWeight,
  input logic [WW-1:0] weights
);
  // cycles since an accepted start, saturating
  logic [3:0] sinceStart;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= '0;
    else if (start && !busy) sinceStart <= 4'd1;
    else if (sinceStart != '0 && sinceStart != 4'hF) sinceStart <= sinceStart + 1'b1;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // a restarted pass (R9 violated) would push done past this point
  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sinceStart == 4'd9);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_weight_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !writeWeight |=> $stable(weights));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadStage, writeWeight}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(loadStage || writeWeight));
endmodule

bind rule_weight_decoder rwd_checker #(.WW(rwd_pkg::RULE_COUNT * GW)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .loadStage   (seqStrobe.loadStage),
  .writeWeight (seqStrobe.writeWeight),
  .weights     (weights)
);

// File: tb/rule_weight_decoder_tb_top.sv
module rule_weight_decoder_tb_top;
  function automatic logic [23:0] tz(int p1, int p2, int p3, int p4);
    return {6'(p4), 6'(p3), 6'(p2), 6'(p1)};
  endfunction

  localparam int NV = 3;
  // stimulus: input X, input Y, X antecedents {r3,r2,r1,r0}, Y antecedents, expected {w3,w2,w1,w0}
  localparam logic [23:0] VX [NV] = '{tz(20,25,30,35), tz(30,30,30,30), tz(10,20,30,40)};
  localparam logic [23:0] VY [NV] = '{tz(10,12,14,16), tz(5,10,20,25), tz(0,0,63,63)};
  localparam logic [95:0] VAX [NV] = '{
    {tz(0,0,63,63), tz(10,15,20,30), tz(0,5,10,15), tz(20,25,30,35)},
    {tz(0,0,63,63), tz(31,32,33,40), tz(20,25,28,35), tz(10,20,40,50)},
    {tz(30,32,34,36), tz(0,2,5,11), tz(40,50,60,63), tz(0,5,8,10)}};
  localparam logic [95:0] VAY [NV] = '{
    {tz(15,20,40,50), tz(0,0,63,63), tz(0,0,63,63), tz(10,12,14,16)},
    {tz(5,10,20,25), tz(0,0,63,63), tz(0,0,63,63), tz(20,25,30,40)},
    {tz(0,0,63,63), tz(0,0,63,63), tz(0,0,63,63), tz(0,0,63,63)}};
  localparam logic [15:0] VEXP [NV] = '{16'h2A0F, 16'hF0A7, 16'hC000};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] xIn = '0, yIn = '0;
  logic [95:0] antX = '0, antY = '0;
  logic [15:0] weights;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rule_weight_decoder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .yIn(yIn),
    .antX(antX), .antY(antY), .weights(weights), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(int v);
    xIn = VX[v]; yIn = VY[v]; antX = VAX[v]; antY = VAY[v];
  endtask

  // raises start for one edge; returns at the negedge after the accepting edge
  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // counts negedges until done; the expected count is 8
  task automatic waitDone(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 weights in reset", 32'(weights), 32'h0);
    check("R1 done in reset", 32'(done), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 weights after reset", 32'(weights), 32'h0);

    // table walk: R2 R3 R4 R5 R6 values, R7 timing
    for (int v = 0; v < NV; v++) begin
      load(v);
      kick();
      waitDone(n);
      check("R7 done latency", 32'(n), 32'd8);
      for (int k = 0; k < 4; k++)
        check("R2 R3 R4 R5 R6 slot weight", 32'(weights[k*4 +: 4]), 32'(VEXP[v][k*4 +: 4]));
      @(negedge clk);
      check("R7 done single cycle", 32'(done), 32'h0);
    end

    // R8 write order: previous C000, new F0A7
    load(1);
    kick();
    @(negedge clk);
    check("R8 nothing written after one edge", 32'(weights), 32'hC000);
    @(negedge clk);
    check("R8 slot0 first", 32'(weights), 32'hC007);
    repeat (2) @(negedge clk);
    check("R8 slot1 second", 32'(weights), 32'hC0A7);
    repeat (4) @(negedge clk);
    check("R8 all slots at done", 32'(weights), 32'hF0A7);
    check("R8 done with final slot", 32'(done), 32'h1);

    // R9 start during a pass is ignored
    load(0);
    kick();
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (n == 3) start = 1'b1;
      if (n == 4) start = 1'b0;
      if (done) break;
    end
    check("R9 done not moved", 32'(n), 32'd8);
    check("R9 weights of first pass", 32'(weights), 32'h2A0F);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) n++;
    end
    check("R9 no second pass", 32'(n), 32'd0);

    // R10 hold between passes despite input changes
    antX = '0; antY = {4{tz(1,2,3,4)}}; xIn = tz(60,61,62,63); yIn = tz(0,0,1,1);
    repeat (6) @(negedge clk);
    check("R10 weights held", 32'(weights), 32'h2A0F);
    check("R10 no done while idle", 32'(done), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule